// File: doc/BRIEF.md
# Cascadable Eight-Line Priority Interrupt Controller

This block collects up to eight interrupt request lines, latches each rising edge, and passes the most urgent unmasked request to a processor. The request goes out as a single interrupt output. When the processor acknowledges it, the block returns an 8-bit vector and marks the line as in service. No more deliveries come from that line or from any line of lower priority until software writes an end-of-interrupt command.

Software reaches the block through a byte-wide port with two addresses. One is the command address and the other is the data address. After reset the block is not ready and throws away every request. A fixed four-write sequence makes it ready: an init command, then three data writes. These set the vector base, the cascade wiring and the operating mode. After that, data-address writes load the mask and command-address writes carry end-of-interrupt commands.

Two instances can be chained. A strap input picks the role of each. The slave's interrupt output drives one request input of the master. When the processor acknowledges that input, the master sends the acknowledge on to the slave with the line number, and the slave supplies the vector.

Top module: `irq_ctrl8`

## Requirements
- R1: After reset the mask reads 0x00 and int_out is low. Until initialization completes, int_out stays low and request edges are thrown away.
- R2: A command-address write (addr=0) of 0x11 starts initialization from any state and clears the mask, pending and in-service state. The next three data-address writes (addr=1) are the vector base, the cascade word and the mode word. The block is ready after the third of them.
- R3: A delivered request on line n produces vector base+n; with base 0x20, line 0 gives 0x20 and line 3 gives 0x23.
- R4: Once ready, a data-address write loads the mask (bit n = 1 masks line n), and a read at the data address returns the mask. A masked line keeps its request latched and is delivered once it is unmasked.
- R5: Line 0 has the highest priority and line 7 the lowest. Of several pending unmasked lines, the lowest-numbered one is delivered first.
- R6: Requests are rising-edge triggered: a line held high is delivered once, and it needs a new rising edge to request again.
- R7: A request is offered only if its line has strictly higher priority than every line in service. Equal or lower lines wait, and higher lines can nest.
- R8: A command-address write of 0x20 while ready clears the highest-priority in-service bit.
- R9: An acknowledge while int_out is high causes vec_valid to be high for one cycle, on the cycle after the acknowledge. An acknowledge with nothing deliverable produces no vector.
- R10: A master (cfg_master=1) whose cascade word has bit n set does not drive a vector when it acknowledges line n. Instead it pulses casc_ack_o for one cycle with casc_id_o = n.
- R11: A slave (cfg_master=0) takes its identity from the low three bits of its cascade word. It treats casc_ack_i as an acknowledge only when casc_id_i equals that identity, and then drives the vector one cycle later.
- R12: A request that comes through a slave must be ended on both instances. Until the master receives its end-of-interrupt, the master's cascade line blocks further deliveries through it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_master | input | 1 | 1 = master role, 0 = slave role |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | 0 = command address, 1 = data address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Mask at the data address, 0x00 at the command address |
| irq_in | input | 8 | Request lines, rising-edge sensitive |
| int_out | output | 1 | Interrupt request to the processor or to the master |
| ack_in | input | 1 | Processor acknowledge (used in master role) |
| vec_valid | output | 1 | Vector valid strobe |
| vec_out | output | 8 | Interrupt vector |
| casc_ack_i | input | 1 | Forwarded acknowledge from a master |
| casc_id_i | input | 3 | Line number forwarded by the master |
| casc_ack_o | output | 1 | Forwarded acknowledge to a slave |
| casc_id_o | output | 3 | Line number sent with casc_ack_o |

## Verification
The bench chains a master and a slave and runs the standard remap sequence on both. Simultaneous requests on two master lines separate priority order from arrival order. A line held high through its end-of-interrupt shows edge triggering as opposed to level triggering. A higher line raised while a lower one is in service tells nesting apart from blanket blocking. A request on a masked line, unmasked later, shows that masking defers a request and does not drop it. Slave requests check that the vector comes from the slave and not the master. They also check that ending the interrupt on the slave alone leaves the master blocked. A restart with a request pending checks that re-initialization clears the block.

// File: rtl/irq_ctrl8_pkg.sv
// Package: shared state encoding, command codes and a priority helper.
// Assumes at most 32 request lines for the helper function.
package irq_ctrl8_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BASE,
        ST_CASC,
        ST_MODE,
        ST_RUN
    } init_st_t;

    localparam logic [7:0] CMD_INIT = 8'h11;
    localparam logic [7:0] CMD_EOI  = 8'h20;

    // Index of the lowest set bit; 32 when the vector is empty.
    function automatic int unsigned first_set(input logic [31:0] v);
        int unsigned r;
        r = 32;
        for (int i = 31; i >= 0; i--) begin
            if (v[i]) r = i;
        end
        return r;
    endfunction

endpackage

// File: rtl/irq_cfg_regs.sv
// Register port and initialization sequencer. It holds the vector base,
// the cascade word and the mask, and decodes the init and EOI commands.
// Assumes NLINES <= DW, so that the mask fits in one data write.
module irq_cfg_regs
    import irq_ctrl8_pkg::*;
#(
    parameter int NLINES = 8,
    parameter int DW     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    output logic              ready,
    output logic              init_pulse,
    output logic              eoi_pulse,
    output logic [NLINES-1:0] imr,
    output logic [DW-1:0]     base,
    output logic [DW-1:0]     casc_word
);

    init_st_t state;

    // Command decode, valid in the cycle of the write.
    always_comb begin
        init_pulse = wr_en && !addr && (wdata == CMD_INIT);
        eoi_pulse  = wr_en && !addr && (wdata == CMD_EOI) && (state == ST_RUN);
        ready      = (state == ST_RUN);
        rdata      = addr ? DW'(imr) : '0;
    end

    // Step through the init words; once running, data writes load the mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            imr       <= '0;
            base      <= '0;
            casc_word <= '0;
        end else if (init_pulse) begin
            state <= ST_BASE;
            imr   <= '0;
        end else if (wr_en && addr) begin
            case (state)
                ST_BASE: begin
                    base  <= wdata;
                    state <= ST_CASC;
                end
                ST_CASC: begin
                    casc_word <= wdata;
                    state     <= ST_MODE;
                end
                ST_MODE: state <= ST_RUN;
                ST_RUN:  imr   <= wdata[NLINES-1:0];
                default: ;
            endcase
        end
    end

    // R4
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && wr_en && addr) |=> (imr == $past(wdata[NLINES-1:0])));

    // R2
    init_clears_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_pulse |=> (!ready && imr == '0));

endmodule

// File: rtl/irq_req_latch.sv
// Request latch: it catches rising edges of the inputs in a pending
// register and clears the bit that is acknowledged. Assumes the inputs
// are already synchronous to clk. Edges are thrown away while not ready.
module irq_req_latch #(
    parameter int NLINES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ready,
    input  logic [NLINES-1:0] irq_in,
    input  logic [NLINES-1:0] clr_mask,
    output logic [NLINES-1:0] irr
);

    logic [NLINES-1:0] irq_prev;

    // Record the previous input level and latch new rising edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_prev <= '0;
            irr      <= '0;
        end else begin
            irq_prev <= irq_in;
            irr      <= ready ? ((irr & ~clr_mask) | (irq_in & ~irq_prev)) : '0;
        end
    end

    // R6
    req_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((irr & ~$past(irr) & ~$past(irq_in)) == '0));

endmodule

// File: rtl/irq_prio_resolve.sv
// Priority resolver, purely combinational. It picks the lowest-numbered
// pending unmasked line and raises a request only if that line has
// strictly higher priority than every in-service line.
module irq_prio_resolve
    import irq_ctrl8_pkg::*;
#(
    parameter int NLINES = 8
) (
    input  logic                      ready,
    input  logic [NLINES-1:0]         irr,
    input  logic [NLINES-1:0]         imr,
    input  logic [NLINES-1:0]         isr,
    output logic                      int_req,
    output logic [$clog2(NLINES)-1:0] line_idx
);

    localparam int IDX_W = $clog2(NLINES);

    logic [NLINES-1:0] pend;
    int unsigned       p_idx;
    int unsigned       s_idx;

    // Compare the best pending line against the best in-service line.
    always_comb begin
        pend     = irr & ~imr;
        p_idx    = first_set(32'(pend));
        s_idx    = first_set(32'(isr));
        int_req  = ready && (pend != '0) && (p_idx < s_idx);
        line_idx = IDX_W'(p_idx);
    end

endmodule

// File: rtl/irq_service.sv
// In-service tracking and acknowledge path. It moves the acknowledged line
// from pending to in-service, then either drives the vector or, for a
// cascade line on a master, forwards the acknowledge with the line number.
// Assumes int_req and line_idx come from the resolver in the same cycle.
module irq_service #(
    parameter int NLINES = 8,
    parameter int DW     = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      init_pulse,
    input  logic                      eoi_pulse,
    input  logic                      cfg_master,
    input  logic                      ack_cpu,
    input  logic                      casc_ack_i,
    input  logic [$clog2(NLINES)-1:0] casc_id_i,
    input  logic [DW-1:0]             casc_word,
    input  logic [DW-1:0]             base,
    input  logic                      int_req,
    input  logic [$clog2(NLINES)-1:0] line_idx,
    output logic [NLINES-1:0]         isr,
    output logic [NLINES-1:0]         clr_mask,
    output logic                      vec_valid,
    output logic [DW-1:0]             vec_out,
    output logic                      casc_ack_o,
    output logic [$clog2(NLINES)-1:0] casc_id_o
);

    localparam int IDX_W = $clog2(NLINES);

    logic              ack_eff;
    logic              take;
    logic              to_slave;
    logic [NLINES-1:0] sel;
    logic [NLINES-1:0] isr_lo;

    // Work out the effective acknowledge and where its response goes.
    always_comb begin
        ack_eff  = cfg_master ? ack_cpu
                              : (casc_ack_i && (casc_id_i == casc_word[IDX_W-1:0]));
        take     = ack_eff && int_req;
        sel      = NLINES'(1) << line_idx;
        clr_mask = take ? sel : '0;
        to_slave = cfg_master && casc_word[line_idx];
        isr_lo   = isr & (~isr + 1'b1);
    end

    // Update in-service: EOI clears the top bit, acknowledge sets a bit.
    always_ff @(posedge clk) begin
        if (!rst_n || init_pulse) begin
            isr <= '0;
        end else begin
            isr <= (eoi_pulse ? (isr & ~isr_lo) : isr) | (take ? sel : '0);
        end
    end

    // Register the vector strobe or the forwarded acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_valid  <= 1'b0;
            vec_out    <= '0;
            casc_ack_o <= 1'b0;
            casc_id_o  <= '0;
        end else begin
            vec_valid  <= take && !to_slave;
            casc_ack_o <= take && to_slave;
            if (take) begin
                vec_out   <= base + DW'(line_idx);
                casc_id_o <= line_idx;
            end
        end
    end

    // R9
    vec_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> $past(ack_eff));

    // R10
    casc_no_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(vec_valid && casc_ack_o));

    // R7
    isr_single_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(isr & ~$past(isr)));

    // R8
    eoi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_pulse && !take && isr != '0) |=> ($countones(isr) == $countones($past(isr)) - 1));

endmodule

// File: rtl/irq_ctrl8.sv
// Top of the cascadable priority interrupt controller. It wires the
// register port, the request latch, the priority resolver and the service
// logic together. Assumes all inputs are synchronous to clk.
module irq_ctrl8 #(
    parameter int NLINES = 8,
    parameter int DW     = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_master,
    input  logic                      wr_en,
    input  logic                      addr,
    input  logic [DW-1:0]             wdata,
    output logic [DW-1:0]             rdata,
    input  logic [NLINES-1:0]         irq_in,
    output logic                      int_out,
    input  logic                      ack_in,
    output logic                      vec_valid,
    output logic [DW-1:0]             vec_out,
    input  logic                      casc_ack_i,
    input  logic [$clog2(NLINES)-1:0] casc_id_i,
    output logic                      casc_ack_o,
    output logic [$clog2(NLINES)-1:0] casc_id_o
);

    localparam int IDX_W = $clog2(NLINES);

    logic              ready;
    logic              init_pulse;
    logic              eoi_pulse;
    logic [NLINES-1:0] imr;
    logic [NLINES-1:0] irr;
    logic [NLINES-1:0] isr;
    logic [NLINES-1:0] clr_mask;
    logic [DW-1:0]     base;
    logic [DW-1:0]     casc_word;
    logic [IDX_W-1:0]  line_idx;

    irq_cfg_regs #(.NLINES(NLINES), .DW(DW)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .rdata      (rdata),
        .ready      (ready),
        .init_pulse (init_pulse),
        .eoi_pulse  (eoi_pulse),
        .imr        (imr),
        .base       (base),
        .casc_word  (casc_word)
    );

    irq_req_latch #(.NLINES(NLINES)) u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .ready    (ready),
        .irq_in   (irq_in),
        .clr_mask (clr_mask),
        .irr      (irr)
    );

    irq_prio_resolve #(.NLINES(NLINES)) u_prio (
        .ready    (ready),
        .irr      (irr),
        .imr      (imr),
        .isr      (isr),
        .int_req  (int_out),
        .line_idx (line_idx)
    );

    irq_service #(.NLINES(NLINES), .DW(DW)) u_svc (
        .clk        (clk),
        .rst_n      (rst_n),
        .init_pulse (init_pulse),
        .eoi_pulse  (eoi_pulse),
        .cfg_master (cfg_master),
        .ack_cpu    (ack_in),
        .casc_ack_i (casc_ack_i),
        .casc_id_i  (casc_id_i),
        .casc_word  (casc_word),
        .base       (base),
        .int_req    (int_out),
        .line_idx   (line_idx),
        .isr        (isr),
        .clr_mask   (clr_mask),
        .vec_valid  (vec_valid),
        .vec_out    (vec_out),
        .casc_ack_o (casc_ack_o),
        .casc_id_o  (casc_id_o)
    );

    // R1
    int_only_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> ready);

    // R5
    prio_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> ((irr & ~imr & ((NLINES'(1) << line_idx) - 1'b1)) == '0));

endmodule

// File: tb/irq_ctrl8_test.sv
// Scoreboard bench: a master and a slave in cascade. Driver tasks push
// expected vectors into a queue, and a monitor pops them as vectors appear.
module irq_ctrl8_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_wr = 1'b0, m_a = 1'b0, s_wr = 1'b0, s_a = 1'b0;
    logic [7:0] m_d = '0, s_d = '0;
    logic [7:0] m_rd, s_rd;
    logic [7:0] m_irq = '0, s_irq = '0;
    logic       cpu_ack = 1'b0;
    logic       m_int, s_int, m_vv, s_vv, m_cack, s_cack;
    logic [7:0] m_vec, s_vec;
    logic [2:0] m_cid, s_cid;

    int checks = 0;
    int fails  = 0;
    logic [8:0] exp_q[$];

    always #5 clk = ~clk;

    irq_ctrl8 uut (
        .clk(clk), .rst_n(rst_n), .cfg_master(1'b1),
        .wr_en(m_wr), .addr(m_a), .wdata(m_d), .rdata(m_rd),
        .irq_in({m_irq[7:3], s_int, m_irq[1:0]}), .int_out(m_int),
        .ack_in(cpu_ack), .vec_valid(m_vv), .vec_out(m_vec),
        .casc_ack_i(1'b0), .casc_id_i(3'd0),
        .casc_ack_o(m_cack), .casc_id_o(m_cid)
    );

    irq_ctrl8 slv (
        .clk(clk), .rst_n(rst_n), .cfg_master(1'b0),
        .wr_en(s_wr), .addr(s_a), .wdata(s_d), .rdata(s_rd),
        .irq_in(s_irq), .int_out(s_int),
        .ack_in(1'b0), .vec_valid(s_vv), .vec_out(s_vec),
        .casc_ack_i(m_cack), .casc_id_i(m_cid),
        .casc_ack_o(s_cack), .casc_id_o(s_cid)
    );

    task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: compare each vector (source bit, value) with the queue head.
    always @(negedge clk) begin
        if (rst_n && (m_vv || s_vv)) begin
            if (exp_q.size() == 0) begin
                chk("R9 unexpected vector", {s_vv, (s_vv ? s_vec : m_vec)}, 9'h1ff);
            end else begin
                chk("R3/R11 vector", {s_vv, (s_vv ? s_vec : m_vec)}, exp_q.pop_front());
            end
        end
    end

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic wr(input bit sl, input logic a, input logic [7:0] d);
        @(negedge clk);
        if (sl) begin s_wr = 1'b1; s_a = a; s_d = d; end
        else    begin m_wr = 1'b1; m_a = a; m_d = d; end
        @(negedge clk);
        m_wr = 1'b0; s_wr = 1'b0; m_a = 1'b0; s_a = 1'b0;
    endtask

    task automatic init(input bit sl, input logic [7:0] b, input logic [7:0] c);
        wr(sl, 1'b0, 8'h11);
        wr(sl, 1'b1, b);
        wr(sl, 1'b1, c);
        wr(sl, 1'b1, 8'h01);
    endtask

    task automatic rd_mask(input bit sl, input logic [7:0] exp, input string req);
        @(negedge clk);
        m_a = 1'b1; s_a = 1'b1;
        #1;
        chk(req, {1'b0, sl ? s_rd : m_rd}, {1'b0, exp});
        m_a = 1'b0; s_a = 1'b0;
    endtask

    // Driver: push the expected vector, acknowledge, confirm it was consumed.
    task automatic ack_expect(input bit sl, input logic [7:0] v, input string req);
        exp_q.push_back({sl, v});
        @(negedge clk) cpu_ack = 1'b1;
        @(negedge clk) cpu_ack = 1'b0;
        settle();
        chk(req, 9'(exp_q.size()), 9'd0);
    endtask

    task automatic chk_int(input logic act, input logic exp, input string req);
        chk(req, {8'd0, act}, {8'd0, exp});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state, requests ignored before init
        chk_int(m_int, 1'b0, "R1 int after reset");
        rd_mask(1'b0, 8'h00, "R1 mask after reset");
        m_irq[0] = 1'b1;
        settle();
        chk_int(m_int, 1'b0, "R1 no int before init");
        m_irq[0] = 1'b0;

        // R2: remap sequence on both instances
        init(1'b0, 8'h20, 8'h04);
        init(1'b1, 8'h28, 8'h02);
        settle();
        chk_int(m_int, 1'b0, "R1 early edge discarded");
        wr(1'b0, 1'b1, 8'hFF);
        wr(1'b1, 1'b1, 8'hFF);
        rd_mask(1'b0, 8'hFF, "R4 master mask all");
        wr(1'b0, 1'b1, 8'hF8);
        wr(1'b1, 1'b1, 8'hFC);
        rd_mask(1'b1, 8'hFC, "R4 slave mask");

        // R5: lines 1 and 0 together; 0 first, then R7 block, R8 EOI
        m_irq[1:0] = 2'b11;
        settle();
        chk_int(m_int, 1'b1, "R5 int raised");
        ack_expect(1'b0, 8'h20, "R3 R5 line0 first");
        chk_int(m_int, 1'b0, "R7 lower blocked by in-service");
        wr(1'b0, 1'b0, 8'h20);
        settle();
        chk_int(m_int, 1'b1, "R8 EOI releases line1");
        ack_expect(1'b0, 8'h21, "R5 line1 second");
        wr(1'b0, 1'b0, 8'h20);
        m_irq[1:0] = 2'b00;
        settle();

        // R6: held-high line delivered once
        m_irq[0] = 1'b1;
        settle();
        ack_expect(1'b0, 8'h20, "R6 first delivery");
        wr(1'b0, 1'b0, 8'h20);
        settle();
        chk_int(m_int, 1'b0, "R6 no redelivery while held");
        m_irq[0] = 1'b0;
        settle();

        // R7: nesting of a higher line over a lower one
        m_irq[1] = 1'b1;
        settle();
        ack_expect(1'b0, 8'h21, "R7 lower in service");
        m_irq[0] = 1'b1;
        settle();
        chk_int(m_int, 1'b1, "R7 higher nests");
        ack_expect(1'b0, 8'h20, "R7 nested vector");
        wr(1'b0, 1'b0, 8'h20);
        wr(1'b0, 1'b0, 8'h20);
        m_irq[1:0] = 2'b00;
        settle();
        chk_int(m_int, 1'b0, "R8 all ended");

        // R4: masked request deferred, delivered on unmask
        m_irq[3] = 1'b1;
        settle();
        chk_int(m_int, 1'b0, "R4 masked line silent");
        wr(1'b0, 1'b1, 8'hF0);
        settle();
        chk_int(m_int, 1'b1, "R4 unmasked pending delivers");
        ack_expect(1'b0, 8'h23, "R3 line3 vector");
        wr(1'b0, 1'b0, 8'h20);
        m_irq[3] = 1'b0;

        // R9: acknowledge with nothing deliverable
        @(negedge clk) cpu_ack = 1'b1;
        @(negedge clk) cpu_ack = 1'b0;
        settle();
        chk("R9 spurious ack", 9'(exp_q.size()), 9'd0);

        // R10 R11: slave line 1 through master line 2
        s_irq[1] = 1'b1;
        settle();
        chk_int(m_int, 1'b1, "R10 cascade int");
        ack_expect(1'b1, 8'h29, "R10 R11 slave vector");

        // R12: slave-only EOI leaves master blocked
        s_irq[0] = 1'b1;
        settle();
        chk_int(s_int, 1'b1, "R12 slave nests");
        chk_int(m_int, 1'b0, "R12 master blocked");
        wr(1'b1, 1'b0, 8'h20);
        settle();
        chk_int(m_int, 1'b0, "R12 still blocked after slave EOI");
        wr(1'b0, 1'b0, 8'h20);
        settle();
        chk_int(m_int, 1'b1, "R12 released after master EOI");
        ack_expect(1'b1, 8'h28, "R12 slave line0 vector");
        wr(1'b1, 1'b0, 8'h20);
        wr(1'b0, 1'b0, 8'h20);
        s_irq[1:0] = 2'b00;
        settle();

        // R2: restart clears pending and mask
        m_irq[1] = 1'b1;
        settle();
        chk_int(m_int, 1'b1, "R2 pending before restart");
        wr(1'b0, 1'b0, 8'h11);
        settle();
        chk_int(m_int, 1'b0, "R2 restart drops int");
        rd_mask(1'b0, 8'h00, "R2 restart clears mask");
        wr(1'b0, 1'b1, 8'h20);
        wr(1'b0, 1'b1, 8'h04);
        wr(1'b0, 1'b1, 8'h01);
        settle();
        chk_int(m_int, 1'b0, "R2 held line no edge after restart");
        m_irq[1] = 1'b0;
        settle();

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule